// File: doc/BRIEF.md
# Port Change-of-State Interrupt Controller

This block watches the input lines of six 8-bit parallel ports, arranged as two groups of three (A, B, C), and records which ports had a line toggle. When a recorded bit appears, it raises an interrupt request. The request has the shape a shared, wired interrupt line needs: a low phase, then a rising edge, then release.

Software programs a per-port mask with one bit for each 8-bit port. It reads an 8-bit status in which each port C is split into its low and high nibbles. The status can be cleared in two ways: by a write of any value to one location, or by a read of another location that returns the status and clears it in the same access.

The input lines are synchronised with two flops, and each line is compared with its value one clock earlier. The interrupt line is modelled as two pins: a drive enable, and the level driven while that enable is high.

Top module: `port_change_irq`

## Requirements
- R1: After reset, the mask register at offset 0x0B reads 0xFF, the status at offset 0x0F reads 0x00, and the interrupt line is released (`irq_oe`=0).
- R2: A write to offset 0x0B stores data bits 5:0 as the mask. Mask bit 0 is group 0 port A, bit 1 group 0 B, bit 2 group 0 C, bit 3 group 1 A, bit 4 group 1 B and bit 5 group 1 C. Data bits 7:6 are ignored, and they always read back as 1.
- R3: A mask bit of 1 disables its port: toggling that port's lines leaves the status unchanged. A mask bit of 0 enables the port.
- R4: `port_in` byte k carries one port: k=0 is group 0 A, 1 is group 0 B, 2 is group 0 C, 3 is group 1 A, 4 is group 1 B and 5 is group 1 C. For each enabled port, a toggle sets a status bit. Status bit 0 is group 0 A, bit 1 group 0 B, bit 2 group 0 C low nibble, bit 3 group 0 C high nibble, bit 4 group 1 A, bit 5 group 1 B, bit 6 group 1 C low nibble and bit 7 group 1 C high nibble.
- R5: A change applied to `port_in` becomes visible in the status on the third rising clock edge after it is applied, and not before.
- R6: Status bits are sticky. Reading offset 0x0F returns the status and does not clear it.
- R7: A write of any value to offset 0x0F clears the whole status.
- R8: A read of offset 0x18 returns the status and clears it at the end of that access.
- R9: If a change arrives in the same cycle as a clear, that change's status bit remains set. All other bits are cleared.
- R10: An interrupt pulse drives the line low for LOW_CYCLES clocks, then drives it high for one clock, then releases it. The line is never driven outside a pulse.
- R11: A pulse starts only when some status bit goes from 0 to 1 while no pulse is in progress. New bits that appear during a pulse do not start or extend a pulse. A toggle on a port whose status bit is already set starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_in | input | 48 | Raw port input lines, one byte per port |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid during the read cycle |
| irq_oe | output | 1 | Interrupt line drive enable |
| irq_out | output | 1 | Level driven on the interrupt line while enabled |

## Verification
The checker examines the pulse shape on every cycle. It verifies that each pulse starts low, that the low phase lasts exactly LOW_CYCLES clocks, that the high phase lasts one clock and is followed by release, and that the line is high only while driven. It also checks on every cycle that status bits never drop without a clear access, and that the mask reads back with its top bits set. Only the bench scenarios can show the rest: the mapping from each port and nibble to its status bit, the effect of the mask, the three-edge latency, the two clear paths, a change winning over a clear in the same cycle, and the rule that only a 0-to-1 status transition in the idle state starts a new pulse.

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int LOW_CYCLES = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] port_in,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_oe,
  output logic        irq_out
);
  localparam int CW = $clog2(LOW_CYCLES + 1);
  localparam logic [4:0] A_MASK  = 5'h0B;
  localparam logic [4:0] A_STAT  = 5'h0F;
  localparam logic [4:0] A_RDCLR = 5'h18;

  typedef enum logic [1:0] {IDLE, LOW, HIGH} st_t;

  logic [47:0]   s1, s2, prev;
  logic [1:0]    warm;
  logic [7:0]    mask_q, status;
  logic [7:0]    hit, kept;
  logic [CW-1:0] cnt;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      warm <= '0;
    end else begin
      s1   <= port_in;
      s2   <= s1;
      prev <= s2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  wire [47:0] d  = (warm == 2'd3) ? (s2 ^ prev) : '0;
  wire [5:0]  on = ~mask_q[5:0];

  assign hit = {on[5] & |d[47:44], on[5] & |d[43:40], on[4] & |d[39:32], on[3] & |d[31:24],
                on[2] & |d[23:20], on[2] & |d[19:16], on[1] & |d[15:8],  on[0] & |d[7:0]};

  wire clr  = (reg_wr && reg_addr == A_STAT) || (reg_rd && reg_addr == A_RDCLR);
  assign kept = clr ? 8'h00 : status;
  wire fire = |(hit & ~kept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 8'hFF;
      status <= 8'h00;
    end else begin
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata | 8'hC0;
      status <= kept | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: if (fire) begin
          st  <= LOW;
          cnt <= '0;
        end
        LOW: begin
          if (cnt == CW'(LOW_CYCLES - 1)) st <= HIGH;
          else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign irq_oe  = (st != IDLE);
  assign irq_out = (st == HIGH);

  always_comb begin
    case (reg_addr)
      A_MASK:          reg_rdata = mask_q;
      A_STAT, A_RDCLR: reg_rdata = status;
      default:         reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
  parameter int LOW_CYCLES = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic [7:0] status,
  input logic       irq_oe,
  input logic       irq_out
);
  int lowcnt;
  wire clr_now = (reg_wr && reg_addr == 5'h0F) || (reg_rd && reg_addr == 5'h18);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowcnt <= 0;
    else if (!irq_oe) lowcnt <= 0;
    else if (!irq_out) lowcnt <= lowcnt + 1;
  end

  p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> !irq_out);
  p_high_driven_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_oe);
  p_release_after_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |=> (!irq_out && !irq_oe));
  p_low_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> (lowcnt == LOW_CYCLES));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_now |=> (($past(status) & ~status) == 8'h00));
  p_mask_top_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 5'h0B) |-> (reg_rdata[7:6] == 2'b11));
endmodule

bind port_change_irq port_change_irq_chk #(.LOW_CYCLES(LOW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .status(status), .irq_oe(irq_oe), .irq_out(irq_out)
);

// File: tb/port_change_irq_test.sv
`timescale 1ns/100ps
module port_change_irq_test;
  localparam int LOWC = 100;
  logic clk = 0, rst_n = 0;
  logic [47:0] port_in = '0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_oe, irq_out;

  port_change_irq #(.LOW_CYCLES(LOWC)) uut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_oe(irq_oe), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  int nchk = 0, nbad = 0;
  bit reported = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  int pulses = 0, lowrun = 0, highrun = 0, lowlen = 0, highlen = 0;
  logic prev_oe = 0;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (reg_rd) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nchk++;
      if (reg_rdata !== e) begin
        nbad++;
        $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
      end
    end
    if (irq_oe && !irq_out) lowrun++;
    if (irq_oe && irq_out) highrun++;
    if (!irq_oe && prev_oe) begin
      pulses++;
      lowlen = lowrun;
      highlen = highrun;
      lowrun = 0;
      highrun = 0;
    end
    prev_oe = irq_oe;
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd(logic [4:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_addr = a;
    reg_rd = 1;
    step();
    reg_rd = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] v);
    reg_addr = a;
    reg_wdata = v;
    reg_wr = 1;
    step();
    reg_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    nchk++;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    rd(5'h0B, 8'hFF, "R1 mask after reset");
    rd(5'h0F, 8'h00, "R1 status after reset");
    chk("R1 irq released", irq_oe, 0);

    port_in = '1;
    step(5);
    rd(5'h0F, 8'h00, "R3 all ports masked");
    chk("R3 no pulse while masked", pulses, 0);

    wr(5'h0B, 8'h2A);
    rd(5'h0B, 8'hEA, "R2 mask readback");
    wr(5'h0B, 8'h00);
    rd(5'h0B, 8'hC0, "R2 top bits read as one");

    port_in ^= 48'h1;
    step(2);
    rd(5'h0F, 8'h00, "R5 not before third edge");
    rd(5'h0F, 8'h01, "R5 set on third edge");
    rd(5'h0F, 8'h01, "R6 read at 0x0F keeps status");
    step(LOWC + 10);
    chk("R10 pulse count", pulses, 1);
    chk("R10 low length", lowlen, LOWC);
    chk("R10 high length", highlen, 1);

    wr(5'h0F, 8'h5A);
    rd(5'h0F, 8'h00, "R7 write clears");
    port_in ^= 48'h0000_0002_0000;
    step(4);
    rd(5'h0F, 8'h04, "R4 group0 C low");
    port_in ^= 48'h0000_0040_0000;
    step(4);
    rd(5'h0F, 8'h0C, "R4 group0 C high");
    port_in ^= 48'h8000_0000_0000;
    step(4);
    rd(5'h0F, 8'h8C, "R4 group1 C high");
    port_in ^= 48'h00FF_0000_0000;
    step(4);
    rd(5'h18, 8'hAC, "R8 read-clear returns status");
    rd(5'h0F, 8'h00, "R8 status cleared by read");
    step(LOWC + 10);
    chk("R11 one pulse for burst", pulses, 2);

    wr(5'h0B, 8'h01);
    port_in ^= 48'h0000_FF00_00FF;
    step(4);
    rd(5'h18, 8'h10, "R3 masked group0 A, group1 A seen");
    wr(5'h0B, 8'h3F);
    port_in ^= '1;
    step(4);
    rd(5'h0F, 8'h00, "R3 all masked again");
    step(LOWC + 10);
    chk("R11 pulse count after mask test", pulses, 3);

    wr(5'h0B, 8'h00);
    port_in ^= 48'h0000_0000_FF00;
    step(4);
    rd(5'h0F, 8'h02, "R4 group0 B");
    step(LOWC + 10);
    port_in ^= 48'h1;
    step(2);
    wr(5'h0F, 8'h00);
    rd(5'h0F, 8'h01, "R9 change wins over clear");
    step(LOWC + 10);
    chk("R11 pulse after clear and new bit", pulses, 5);

    port_in ^= 48'h1;
    step(LOWC + 10);
    chk("R11 no pulse for bit already set", pulses, 5);
    rd(5'h0F, 8'h01, "R6 bit still set");
    chk("R10 line released when idle", irq_oe, 0);
    report();
  end
endmodule